// File: doc/BRIEF.md
# Serial Receive Path with Flagged Character Queue

This block is the receive half of an asynchronous serial port. A free-running enable, `rx_tick`, pulses sixteen times per bit period. The block uses it to find the start of each character on the incoming line and to recover eight data bits, sent least significant bit first. It can also check an optional parity bit and the stop bit. Each finished character is written, together with its break, framing-error and parity-error indications, into a 16-entry first-in first-out queue.

The consumer drains the queue through a valid/ready stream. `m_valid` is high while the queue is not empty. The entry at the head, with its data and flags, stays stable until a cycle in which `m_valid` and `m_ready` are both high. That cycle removes exactly one entry. The serial line cannot be stalled, so back-pressure is absorbed by the queue. Once the queue is full, further characters are dropped and recorded in a sticky overrun flag.

Alongside the queue the block reports the fill level, an empty indication, a level interrupt with a selectable threshold, and a sticky idle-timeout flag. It also drives the active-low request-to-send output. That output comes either from a software bit or, when automatic control is enabled, from a comparison of the fill level against a programmable threshold.

Top module: `serq_rx`

## Requirements
- R1: Sample timing. A low line seen on a tick while idle is sample 0 of a start bit. The start is confirmed only if sample 8 is still low; otherwise the receiver returns to idle and records nothing. Every data, parity and stop bit takes the majority of its samples 7, 8 and 9, so a single wrong sample does not change the bit.
- R2: Queue and stream. The queue holds 16 entries in arrival order, and `fill` (5 bits) equals the number stored. `rx_empty` is high exactly when `fill` is 0. While `m_valid` is high and `m_ready` is low, the head entry does not change.
- R3: Error flags. `m_ferr` is set for a character whose stop bit was sampled low. With `par_en` high, a parity bit follows the data. `par_odd`=0 expects an even count of ones over the data and parity bits, and `par_odd`=1 expects an odd count. A mismatch sets `m_perr`.
- R4: Break. A break is a character whose data bits, parity bit (if enabled) and stop bit are all 0. It is stored with `m_brk`=1, `m_ferr`=0 and `m_perr`=0, and data 0. After any character with a low stop bit, no new start is accepted until the line has returned high.
- R5: Level interrupt. `lvl_irq` is high while `fill` is at least the selected level. `irq_lvl_sel` values 0, 1, 2 and 3 select 1, 4, 8 and 12 entries.
- R6: Timeout. `tout_flag` is set once the queue has held at least one entry for 64 ticks with no new character arriving. It stays set until a cycle with `tout_clr` high, and it is never set while the queue is empty.
- R7: Overrun. A character that completes while the queue holds 16 entries and no entry is removed in that cycle is discarded: `fill` and the stored entries do not change. `ovr_flag` is set and stays set until a cycle with `ovr_clr` high.
- R8: Automatic flow control. With `rts_auto` high, `rts_n` is 1 (deasserted) while `fill` is at least `rts_lvl`, and 0 otherwise.
- R9: Software flow control. With `rts_auto` low, `rts_n` equals `rts_sw`, so a 1 in the software bit holds the request deasserted.
- R10: Receive disable. While `rx_off` is high, no character is captured and the queue does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial input line, idle high |
| rx_off | input | 1 | Receive disable |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| irq_lvl_sel | input | 2 | Level interrupt threshold select |
| rts_auto | input | 1 | Automatic request-to-send control enable |
| rts_lvl | input | 4 | Fill threshold for automatic deassertion |
| rts_sw | input | 1 | Software request-to-send bit (1 = deassert) |
| ovr_clr | input | 1 | Clear pulse for the overrun flag |
| tout_clr | input | 1 | Clear pulse for the timeout flag |
| m_valid | output | 1 | Head entry available |
| m_ready | input | 1 | Consumer takes the head entry |
| m_data | output | 8 | Head character |
| m_brk | output | 1 | Head entry is a break |
| m_ferr | output | 1 | Head entry framing error |
| m_perr | output | 1 | Head entry parity error |
| fill | output | 5 | Number of stored entries |
| rx_empty | output | 1 | Queue empty |
| lvl_irq | output | 1 | Fill at or above selected level |
| ovr_flag | output | 1 | Sticky overrun |
| tout_flag | output | 1 | Sticky idle timeout |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The embedded properties watch several rules on every cycle:

- the fill level never exceeds the depth;
- the head entry holds steady under back-pressure;
- a stored break never carries framing or parity flags;
- overrun rises only from a full queue, and timeout only from a non-empty one;
- nothing is produced while reception is disabled.

Bit recovery is covered only by the bench's scenarios. These include the majority vote against a single flipped sample, rejection of a short start pulse, the parity senses, a break followed by a line that stays low, and the thresholds for interrupt and flow control. In those scenarios a queue model is compared against the ports between frames.

// File: rtl/serq_pkg.sv
package serq_pkg;
  localparam int SERQ_DW = 8;

  typedef struct packed {
    logic               brk;
    logic               ferr;
    logic               perr;
    logic [SERQ_DW-1:0] data;
  } rx_ent_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_HOLD
  } rx_st_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/serq_sampler.sv
module serq_sampler
  import serq_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int SYNC = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    rxd,
  input  logic    rx_off,
  input  logic    par_en,
  input  logic    par_odd,
  output logic    frm_v,
  output rx_ent_t frm
);
  localparam int DW  = SERQ_DW;
  localparam int PW  = $clog2(OSR);
  localparam int BW  = $clog2(DW);
  localparam int MID = OSR / 2;

  logic [SYNC-1:0] sync_q;
  logic            rx_s;
  rx_st_t          st;
  logic [PW-1:0]   ph;
  logic [BW-1:0]   bcnt;
  logic [DW-1:0]   sh;
  logic [1:0]      vote;
  logic            par_b;
  logic            maj;
  logic            brk_w;
  logic            perr_w;

  // input synchroniser, idle-high reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rxd};
  end
  assign rx_s = sync_q[SYNC-1];

  assign maj    = maj3(vote[0], vote[1], rx_s);
  assign brk_w  = (sh == '0) && !maj && (!par_en || !par_b);
  assign perr_w = ((^sh) ^ par_b) != par_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ph    <= '0;
      bcnt  <= '0;
      sh    <= '0;
      vote  <= '0;
      par_b <= 1'b0;
      frm_v <= 1'b0;
      frm   <= '0;
    end else begin
      frm_v <= 1'b0;
      if (rx_off) begin
        st <= S_IDLE;
        ph <= '0;
      end else if (tick) begin
        if (st == S_IDLE) begin
          if (!rx_s) begin
            st <= S_START;
            ph <= PW'(1);
          end
        end else if (st == S_HOLD) begin
          if (rx_s) st <= S_IDLE;
        end else begin
          ph <= ph + 1'b1;
          if (ph == PW'(MID - 1)) vote[0] <= rx_s;
          if (ph == PW'(MID))     vote[1] <= rx_s;
          if (st == S_START && ph == PW'(MID) && rx_s) begin
            st <= S_IDLE;
            ph <= '0;
          end
          if (ph == PW'(MID + 1)) begin
            case (st)
              S_DATA: sh    <= {maj, sh[DW-1:1]};
              S_PAR:  par_b <= maj;
              S_STOP: begin
                frm_v     <= 1'b1;
                frm.data  <= sh;
                frm.brk   <= brk_w;
                frm.ferr  <= !maj && !brk_w;
                frm.perr  <= par_en && perr_w && !brk_w;
                st        <= maj ? S_IDLE : S_HOLD;
                ph        <= '0;
              end
              default: ;
            endcase
          end
          if (ph == PW'(OSR - 1)) begin
            case (st)
              S_START: begin
                st   <= S_DATA;
                bcnt <= '0;
              end
              S_DATA: begin
                if (bcnt == BW'(DW - 1)) st <= par_en ? S_PAR : S_STOP;
                else                     bcnt <= bcnt + 1'b1;
              end
              S_PAR:   st <= S_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end

  // R10: a disabled receiver produces no character
  p_off_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_off |=> !frm_v);
endmodule

// File: rtl/serq_fifo.sv
module serq_fifo
  import serq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  rx_ent_t                    wdat,
  input  logic                       pop_rdy,
  output logic                       m_valid,
  output rx_ent_t                    rdat,
  output logic [$clog2(DEPTH):0]     cnt,
  input  logic                       ovr_clr,
  output logic                       ovr_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  rx_ent_t       mem [DEPTH];
  logic [AW-1:0] wr;
  logic [AW-1:0] rd;
  logic          pop;
  logic          acc;

  assign m_valid = (cnt != '0);
  assign pop     = m_valid && pop_rdy;
  assign acc     = push && ((cnt != CW'(DEPTH)) || pop);
  assign rdat    = mem[rd];

  always_ff @(posedge clk) begin
    if (acc) mem[wr] <= wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr       <= '0;
      rd       <= '0;
      cnt      <= '0;
      ovr_flag <= 1'b0;
    end else begin
      if (acc) wr <= wr + 1'b1;
      if (pop) rd <= rd + 1'b1;
      cnt <= cnt + CW'(acc) - CW'(pop);
      if (push && !acc) ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !pop_rdy |=> m_valid && $stable(rdat));

  p_ovr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(cnt) == CW'(DEPTH));

  p_brk_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && rdat.brk |-> !rdat.ferr && !rdat.perr);
endmodule

// File: rtl/serq_flow.sv
module serq_flow #(
  parameter int DEPTH      = 16,
  parameter int TOUT_TICKS = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   arrive,
  input  logic [$clog2(DEPTH):0] cnt,
  input  logic [1:0]             lvl_sel,
  input  logic                   rts_auto,
  input  logic [$clog2(DEPTH)-1:0] rts_lvl,
  input  logic                   rts_sw,
  input  logic                   tout_clr,
  output logic                   lvl_irq,
  output logic                   tout_flag,
  output logic                   rts_n
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int TW = $clog2(TOUT_TICKS + 1);

  logic [CW-1:0] thr;
  logic [TW-1:0] tmr;

  always_comb begin
    case (lvl_sel)
      2'd0:    thr = CW'(1);
      2'd1:    thr = CW'(4);
      2'd2:    thr = CW'(8);
      default: thr = CW'(12);
    endcase
  end

  assign lvl_irq = (cnt >= thr);
  assign rts_n   = rts_auto ? (cnt >= CW'(rts_lvl)) : rts_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr       <= '0;
      tout_flag <= 1'b0;
    end else begin
      if (arrive || cnt == '0)                 tmr <= '0;
      else if (tick && tmr != TW'(TOUT_TICKS)) tmr <= tmr + 1'b1;

      if (tick && !arrive && cnt != '0 && tmr == TW'(TOUT_TICKS - 1))
        tout_flag <= 1'b1;
      else if (tout_clr)
        tout_flag <= 1'b0;
    end
  end

  p_tout_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout_flag) |-> $past(cnt) != '0);
endmodule

// File: rtl/serq_rx.sv
module serq_rx
  import serq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int OSR        = 16,
  parameter int SYNC       = 2,
  parameter int TOUT_TICKS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_tick,
  input  logic                     rxd,
  input  logic                     rx_off,
  input  logic                     par_en,
  input  logic                     par_odd,
  input  logic [1:0]               irq_lvl_sel,
  input  logic                     rts_auto,
  input  logic [$clog2(DEPTH)-1:0] rts_lvl,
  input  logic                     rts_sw,
  input  logic                     ovr_clr,
  input  logic                     tout_clr,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic [SERQ_DW-1:0]       m_data,
  output logic                     m_brk,
  output logic                     m_ferr,
  output logic                     m_perr,
  output logic [$clog2(DEPTH):0]   fill,
  output logic                     rx_empty,
  output logic                     lvl_irq,
  output logic                     ovr_flag,
  output logic                     tout_flag,
  output logic                     rts_n
);
  logic    frm_v;
  rx_ent_t frm;
  rx_ent_t head;

  serq_sampler #(.OSR(OSR), .SYNC(SYNC)) u_smp (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .rxd(rxd), .rx_off(rx_off),
    .par_en(par_en), .par_odd(par_odd), .frm_v(frm_v), .frm(frm)
  );

  serq_fifo #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(frm_v), .wdat(frm), .pop_rdy(m_ready),
    .m_valid(m_valid), .rdat(head), .cnt(fill), .ovr_clr(ovr_clr),
    .ovr_flag(ovr_flag)
  );

  serq_flow #(.DEPTH(DEPTH), .TOUT_TICKS(TOUT_TICKS)) u_fl (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .arrive(frm_v), .cnt(fill),
    .lvl_sel(irq_lvl_sel), .rts_auto(rts_auto), .rts_lvl(rts_lvl),
    .rts_sw(rts_sw), .tout_clr(tout_clr), .lvl_irq(lvl_irq),
    .tout_flag(tout_flag), .rts_n(rts_n)
  );

  assign m_data   = head.data;
  assign m_brk    = head.brk;
  assign m_ferr   = head.ferr;
  assign m_perr   = head.perr;
  assign rx_empty = !m_valid;

  p_empty_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty == (fill == '0));
endmodule

// File: tb/sim_serq_rx.sv
module sim_serq_rx;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, rx_tick, rxd, rx_off, par_en, par_odd;
  logic [1:0] irq_lvl_sel;
  logic       rts_auto, rts_sw, ovr_clr, tout_clr, m_ready;
  logic [3:0] rts_lvl;
  logic       m_valid, m_brk, m_ferr, m_perr, rx_empty, lvl_irq, ovr_flag, tout_flag, rts_n;
  logic [7:0] m_data;
  logic [4:0] fill;

  serq_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rxd(rxd), .rx_off(rx_off),
    .par_en(par_en), .par_odd(par_odd), .irq_lvl_sel(irq_lvl_sel),
    .rts_auto(rts_auto), .rts_lvl(rts_lvl), .rts_sw(rts_sw), .ovr_clr(ovr_clr),
    .tout_clr(tout_clr), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_brk(m_brk), .m_ferr(m_ferr), .m_perr(m_perr), .fill(fill),
    .rx_empty(rx_empty), .lvl_irq(lvl_irq), .ovr_flag(ovr_flag),
    .tout_flag(tout_flag), .rts_n(rts_n)
  );

  logic [10:0] q[$];
  bit ovr_e = 0;
  bit busy = 1;
  int nchk = 0, nfail = 0, thr, lvl;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference queue compared every clock while no frame is on the line
  always @(posedge clk) begin
    #2;
    if (rst_n && !busy) begin
      thr = (irq_lvl_sel == 0) ? 1 : (irq_lvl_sel == 1) ? 4 : (irq_lvl_sel == 2) ? 8 : 12;
      lvl = int'(rts_lvl);
      chk(int'(fill) == q.size(), "R2", "fill", fill, q.size());
      chk(rx_empty == (q.size() == 0), "R2", "empty", rx_empty, q.size() == 0);
      if (q.size() > 0)
        chk({m_brk, m_ferr, m_perr, m_data} == q[0], "R3", "head",
            {m_brk, m_ferr, m_perr, m_data}, q[0]);
      chk(lvl_irq == (q.size() >= thr), "R5", "lvl_irq", lvl_irq, q.size() >= thr);
      chk(rts_n == (rts_auto ? (q.size() >= lvl) : rts_sw), "R8", "rts_n", rts_n,
          rts_auto ? (q.size() >= lvl) : rts_sw);
      chk(ovr_flag == ovr_e, "R7", "ovr_flag", ovr_flag, ovr_e);
    end
  end

  task automatic drv(input logic v, input int n);
    repeat (n) begin @(negedge clk); rxd = v; end
  endtask

  task automatic send(input logic [7:0] d, input bit badp = 0, input logic stp = 1,
                      input int gl = -1);
    logic pb, bk;
    int nb;
    pb = par_odd ? ~^d : ^d;
    if (badp) pb = ~pb;
    nb = par_en ? 11 : 10;
    busy = 1;
    for (int b = 0; b < nb; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b <= 8) ? d[b-1] : (par_en && b == 9) ? pb : stp;
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        rxd = ((b * 16 + c) == gl) ? ~v : v;
      end
    end
    drv(1'b1, 4);
    bk = (d == 0) && !stp && (!par_en || !pb);
    if (!rx_off) begin
      if (q.size() == 16) ovr_e = 1;
      else q.push_back({bk, !stp && !bk, par_en && badp && !bk, d});
    end
    busy = 0;
  endtask

  task automatic pop1(string req);
    @(negedge clk);
    chk(q.size() > 0 && m_valid && {m_brk, m_ferr, m_perr, m_data} == q[0], req,
        "popped entry", {m_brk, m_ferr, m_perr, m_data}, (q.size() > 0) ? int'(q[0]) : -1);
    m_ready = 1;
    @(posedge clk);
    #1;
    if (q.size() > 0) void'(q.pop_front());
    @(negedge clk);
    m_ready = 0;
  endtask

  task automatic drain(string req);
    while (q.size() > 0) pop1(req);
  endtask

  task automatic pulse_ovr_clr();
    @(negedge clk); ovr_clr = 1;
    @(posedge clk); #1 ovr_e = 0;
    @(negedge clk); ovr_clr = 0;
  endtask

  task automatic pulse_tout_clr();
    @(negedge clk); tout_clr = 1;
    @(negedge clk); tout_clr = 0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    summary();
  end

  initial begin
    int n0;
    rst_n = 0; rx_tick = 1; rxd = 1; rx_off = 0; par_en = 0; par_odd = 0;
    irq_lvl_sel = 0; rts_auto = 0; rts_lvl = 4'd5; rts_sw = 0; ovr_clr = 0;
    tout_clr = 0; m_ready = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(fill == 0 && rx_empty && !m_valid, "R2", "reset queue", fill, 0);
    chk(!ovr_flag && !tout_flag, "R7", "reset flags", {ovr_flag, tout_flag}, 0);
    chk(rts_n == 0, "R9", "reset rts_n", rts_n, 0);
    busy = 0;

    // R1: plain frames, single-sample glitch, short start pulse
    send(8'hA5);
    chk(m_data == 8'hA5 && !m_ferr && !m_perr && !m_brk, "R1", "plain frame", m_data, 8'hA5);
    send(8'h3C, 0, 1, 3 * 16 + 8);
    send(8'hC3, 0, 1, 6 * 16 + 7);
    n0 = fill;
    drv(1'b0, 4); drv(1'b1, 40);
    chk(int'(fill) == n0, "R1", "short start ignored", fill, n0);
    drain("R1");

    // R3: parity senses and framing error
    par_en = 1; par_odd = 0;
    send(8'h07);
    send(8'h07, 1);
    par_odd = 1;
    send(8'h81);
    send(8'h81, 1);
    par_en = 0;
    send(8'h5A, 0, 0);
    drain("R3");

    // R4: break with parity, line kept low, then recovery
    par_en = 1; par_odd = 0;
    busy = 1;
    drv(1'b0, 11 * 16 + 48);
    chk(fill == 1, "R4", "one entry for break", fill, 1);
    chk(m_brk && !m_ferr && !m_perr, "R4", "break flags", {m_brk, m_ferr, m_perr}, 4);
    drv(1'b1, 20);
    q.push_back({1'b1, 1'b0, 1'b0, 8'h00});
    busy = 0;
    send(8'h55);
    chk(fill == 2, "R4", "frame after break", fill, 2);
    drain("R4");
    par_en = 0;

    // R10: receive disabled
    rx_off = 1;
    send(8'h11);
    chk(fill == 0, "R10", "disabled capture", fill, 0);
    rx_off = 0;
    send(8'h22);
    chk(fill == 1, "R10", "re-enabled capture", fill, 1);
    drain("R10");

    // R5 and R8: thresholds
    irq_lvl_sel = 2'd1; rts_auto = 1; rts_lvl = 4'd5;
    for (int i = 0; i < 3; i++) send(8'(i + 1));
    chk(!lvl_irq && !rts_n, "R5", "below 4", {lvl_irq, rts_n}, 0);
    send(8'h04);
    chk(lvl_irq && !rts_n, "R5", "at 4", {lvl_irq, rts_n}, 2);
    send(8'h05);
    chk(rts_n, "R8", "rts deasserted at 5", rts_n, 1);
    irq_lvl_sel = 2'd2;
    @(negedge clk);
    chk(!lvl_irq, "R5", "level 8 not reached", lvl_irq, 0);
    for (int i = 0; i < 3; i++) send(8'(i + 6));
    chk(lvl_irq, "R5", "level 8 reached", lvl_irq, 1);
    irq_lvl_sel = 2'd3;
    @(negedge clk);
    chk(!lvl_irq, "R5", "level 12 not reached", lvl_irq, 0);

    // R9: software control
    rts_auto = 0; rts_sw = 1;
    @(negedge clk);
    chk(rts_n == 1, "R9", "sw deassert", rts_n, 1);
    rts_sw = 0;
    @(negedge clk);
    chk(rts_n == 0, "R9", "sw assert", rts_n, 0);

    // R7: fill to 16, then overrun
    while (q.size() < 16) send(8'(q.size() * 17 + 3));
    chk(lvl_irq, "R5", "level 12 reached", lvl_irq, 1);
    send(8'hEE);
    chk(fill == 16 && ovr_flag, "R7", "overrun drop", {fill, ovr_flag}, {5'd16, 1'b1});
    pulse_ovr_clr();
    chk(!ovr_flag, "R7", "overrun cleared", ovr_flag, 0);
    drain("R7");

    // R6: idle timeout
    pulse_tout_clr();
    repeat (100) @(negedge clk);
    chk(!tout_flag, "R6", "no timeout when empty", tout_flag, 0);
    send(8'h9B);
    pulse_tout_clr();
    chk(!tout_flag, "R6", "timeout not yet", tout_flag, 0);
    repeat (80) @(negedge clk);
    chk(tout_flag, "R6", "timeout raised", tout_flag, 1);
    pulse_tout_clr();
    chk(!tout_flag, "R6", "timeout cleared", tout_flag, 0);
    drain("R6");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule